// File: doc/BRIEF.md
# Floating-point round-to-integral unit

This block takes one 64-bit double-precision operand and returns it rounded to an integral value, still in double-precision format. The rounding variant is chosen by decoding a 32-bit instruction word. Four variants exist: nearest with halves moving away from zero, toward zero, toward plus infinity and toward minus infinity. Each accepted operation produces, one clock after its valid strobe, the rounded value with a target register index and write enable. It also produces the status flag updates for this operation and, when the instruction asks for it, a 4-bit condition-field update.

The surrounding core supplies the operand and the current invalid-operation enable bit together with the instruction word. The unit returns write enables that tell the register file and the status register what to take. Instruction words that are not one of the four forms are reported as not handled and write nothing. A signaling NaN raises the invalid-operation flag. If the invalid enable is set, the result write and the class-code update are withheld so that trap delivery elsewhere sees the old target.

Top module: `fp_round_int`

## Requirements
- R1: Bits are numbered big-endian, with instruction bit 0 being `instr[31]`. The primary opcode is `instr[31:26]`, the target index `instr[25:21]`, the reserved field `instr[20:16]`, the source index `instr[15:11]`, the extended opcode `instr[10:1]` and the record bit `instr[0]`. The result carries the target and source indexes of its instruction.
- R2: The primary opcode must be 63. Extended opcode 392 selects nearest with ties away from zero. Extended opcode 456 rounds toward plus infinity, 424 toward zero, and 488 toward minus infinity.
- R3: Any other primary opcode, any other extended opcode, or a nonzero reserved field sets `unhandled`. It clears `res_we`, `cls_we`, `stat_we` and `cond_we`.
- R4: Every handled operation asserts `stat_we` and reports `flg_fr` = 0 and `flg_fi` = 0, even when the value changed.
- R5: An unbiased exponent of 52 or more, an infinity, a zero or a quiet NaN is returned bit-for-bit unchanged.
- R6: A magnitude below 1.0 gives a zero or a 1.0 that carries the operand's sign. Nearest gives 1.0 only for a magnitude of at least 0.5. Toward plus infinity gives +1.0 only for a positive nonzero operand, and toward minus infinity gives -1.0 only for a negative nonzero operand. For example, -0.3 rounded up gives -0.0.
- R7: A signaling NaN (exponent all ones, nonzero fraction, fraction MSB 0) sets `flg_vxsnan` and `flg_fx`. With `inv_enable` = 0 the result is the same NaN with fraction bit 51 set. With `inv_enable` = 1, `res_we` and `cls_we` are 0.
- R8: `cls_code` is the class and sign of the result: quiet NaN 10001, +infinity 00101, -infinity 01001, +normal 00100, -normal 01000, +zero 00010, -zero 10010.
- R9: With the record bit 1, `cond_we` is 1 and `cond_field` = {exception summary, enabled-exception summary, invalid summary, overflow}. These are {snan, snan & inv_enable, snan, 0}. With the record bit 0, `cond_we` is 0.
- R10: All outputs are registered. `out_valid` is high exactly in the cycle after an `in_valid` cycle. With `out_valid` low, all write enables are 0.
- R11: In the in-range case, nearest, up and down round by the rule of their mode. A carry out of the mantissa raises the exponent by one. Toward zero simply drops the fraction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word |
| src_op | input | 64 | Source operand, double precision |
| inv_enable | input | 1 | Invalid-operation enable bit |
| out_valid | output | 1 | Result cycle |
| res_data | output | 64 | Rounded result |
| res_we | output | 1 | Target register write enable |
| res_idx | output | 5 | Target register index |
| src_idx | output | 5 | Source register index of the completed operation |
| unhandled | output | 1 | Instruction word is not one of the four forms |
| stat_we | output | 1 | Status flag update enable |
| cls_we | output | 1 | Class/sign code update enable |
| cls_code | output | 5 | Class/sign code of the result |
| flg_fr | output | 1 | Fraction-rounded flag value |
| flg_fi | output | 1 | Fraction-inexact flag value |
| flg_vxsnan | output | 1 | Invalid operation for signaling NaN |
| flg_fx | output | 1 | Exception summary set |
| cond_we | output | 1 | Condition field write enable |
| cond_field | output | 4 | Condition field value |

## Verification
Some properties are checked on every cycle. These are the one-cycle timing of `out_valid`, the silence of every write enable on unhandled words and the withholding of the result and class update on a trapped signaling NaN. They also include the sign of each written non-NaN result matching the operand's sign, the index fields echoing the instruction and the record-bit gating of the condition write. Only the bench's scenarios can show that the rounded values themselves are right: the halfway cases, mantissa carries into the exponent, the sub-unity results in each mode, pass-through of large and special operands and the exact class codes. These are compared against a model built on real-number floor and ceiling.

// File: rtl/fpri_pkg.sv
package fpri_pkg;
  localparam int EXP_W     = 11;
  localparam int FRAC_W    = 52;
  localparam int WORD_W    = EXP_W + FRAC_W + 1;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX   = (1 << EXP_W) - 1;
  localparam int INSTR_W   = 32;
  localparam int OPC_W     = 6;
  localparam int IDX_W     = 5;
  localparam int XO_W      = 10;
  localparam int CLS_W     = 5;
  localparam int COND_W    = 4;

  localparam int OPC_FP    = 63;
  localparam int XO_NEAR   = 392;
  localparam int XO_UP     = 456;
  localparam int XO_ZERO   = 424;
  localparam int XO_DOWN   = 488;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_t;

  localparam logic [CLS_W-1:0] CLS_QNAN  = 5'b10001;
  localparam logic [CLS_W-1:0] CLS_PINF  = 5'b00101;
  localparam logic [CLS_W-1:0] CLS_NINF  = 5'b01001;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_PDEN  = 5'b10100;
  localparam logic [CLS_W-1:0] CLS_NDEN  = 5'b11000;
  localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_NZERO = 5'b10010;
endpackage

// File: rtl/fpri_decode.sv
module fpri_decode
  import fpri_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               op_ok,
  output rmode_t             mode,
  output logic [IDX_W-1:0]   tgt_idx,
  output logic [IDX_W-1:0]   srcr_idx,
  output logic               rec_bit
);
  localparam int TGT_HI = INSTR_W - OPC_W - 1;
  localparam int RSV_HI = TGT_HI - IDX_W;
  localparam int SRC_HI = RSV_HI - IDX_W;

  logic [OPC_W-1:0] opc;
  logic [IDX_W-1:0] rsv;
  logic [XO_W-1:0]  xo;
  logic             xo_ok;

  assign opc      = instr[INSTR_W-1 -: OPC_W];
  assign tgt_idx  = instr[TGT_HI -: IDX_W];
  assign rsv      = instr[RSV_HI -: IDX_W];
  assign srcr_idx = instr[SRC_HI -: IDX_W];
  assign xo       = instr[XO_W:1];
  assign rec_bit  = instr[0];

  always_comb begin
    xo_ok = 1'b1;
    mode  = RM_NEAR;
    case (xo)
      XO_W'(XO_NEAR): mode = RM_NEAR;
      XO_W'(XO_UP):   mode = RM_UP;
      XO_W'(XO_ZERO): mode = RM_ZERO;
      XO_W'(XO_DOWN): mode = RM_DOWN;
      default:        xo_ok = 1'b0;
    endcase
  end

  assign op_ok = xo_ok && (opc == OPC_W'(OPC_FP)) && (rsv == '0);
endmodule

// File: rtl/fpri_round.sv
module fpri_round
  import fpri_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  input  rmode_t            mode,
  output logic [WORD_W-1:0] res,
  output logic              is_snan
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int SH_W   = $clog2(FRAC_W + 1);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [FRAC_W-1:0] mask;
  logic [FRAC_W-1:0] keep;
  logic [EXP_W:0]    fc_full;
  logic [SH_W-1:0]   fcount;
  logic              special;
  logic              big;
  logic              tiny;
  logic              nonzero;
  logic              half;
  logic              sticky;
  logic              inc;
  logic              take_one;
  logic [MANT_W:0]   unit;
  logic [MANT_W:0]   sum;

  function automatic logic bump(rmode_t m, logic s, logic h, logic any);
    case (m)
      RM_NEAR: bump = h;
      RM_UP:   bump = !s && any;
      RM_DOWN: bump = s && any;
      default: bump = 1'b0;
    endcase
  endfunction

  assign sgn     = op[WORD_W-1];
  assign ex      = op[WORD_W-2 -: EXP_W];
  assign fr      = op[FRAC_W-1:0];
  assign special = (ex == EXP_W'(EXP_MAX));
  assign big     = (ex >= EXP_W'(BIAS + FRAC_W));
  assign tiny    = (ex < EXP_W'(BIAS));
  assign nonzero = (ex != '0) || (fr != '0);
  assign is_snan = special && (fr != '0) && !fr[FRAC_W-1];

  // number of fraction bits below the binary point
  assign fc_full = (EXP_W+1)'(BIAS + FRAC_W) - {1'b0, ex};
  assign fcount  = fc_full[SH_W-1:0];
  assign mask    = ~({FRAC_W{1'b1}} << fcount);
  assign keep    = fr & ~mask;
  assign half    = |(fr & mask & ~(mask >> 1));
  assign sticky  = |(fr & mask);

  assign inc      = bump(mode, sgn, half, sticky);
  assign take_one = bump(mode, sgn, ex == EXP_W'(BIAS - 1), nonzero);
  assign unit     = (MANT_W+1)'(1) << fcount;
  assign sum      = {2'b01, keep} + (inc ? unit : '0);

  always_comb begin
    if (special) begin
      res = op;
      if (is_snan) res[FRAC_W-1] = 1'b1;
    end else if (big) begin
      res = op;
    end else if (tiny) begin
      res = take_one ? {sgn, EXP_W'(BIAS), FRAC_W'(0)} : {sgn, {(WORD_W-1){1'b0}}};
    end else if (sum[MANT_W]) begin
      res = {sgn, ex + EXP_W'(1), FRAC_W'(0)};
    end else begin
      res = {sgn, ex, sum[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fpri_class.sv
module fpri_class
  import fpri_pkg::*;
(
  input  logic [WORD_W-1:0] val,
  output logic [CLS_W-1:0]  code
);
  logic              s;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;

  assign s = val[WORD_W-1];
  assign e = val[WORD_W-2 -: EXP_W];
  assign f = val[FRAC_W-1:0];

  always_comb begin
    if (e == EXP_W'(EXP_MAX)) begin
      if (f != '0) code = CLS_QNAN;
      else         code = s ? CLS_NINF : CLS_PINF;
    end else if (e == '0) begin
      if (f == '0) code = s ? CLS_NZERO : CLS_PZERO;
      else         code = s ? CLS_NDEN : CLS_PDEN;
    end else begin
      code = s ? CLS_NNORM : CLS_PNORM;
    end
  end
endmodule

// File: rtl/fp_round_int.sv
module fp_round_int
  import fpri_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [WORD_W-1:0]   src_op,
  input  logic                inv_enable,
  output logic                out_valid,
  output logic [WORD_W-1:0]   res_data,
  output logic                res_we,
  output logic [IDX_W-1:0]    res_idx,
  output logic [IDX_W-1:0]    src_idx,
  output logic                unhandled,
  output logic                stat_we,
  output logic                cls_we,
  output logic [CLS_W-1:0]    cls_code,
  output logic                flg_fr,
  output logic                flg_fi,
  output logic                flg_vxsnan,
  output logic                flg_fx,
  output logic                cond_we,
  output logic [COND_W-1:0]   cond_field
);
  logic              dec_ok;
  rmode_t            dec_mode;
  logic [IDX_W-1:0]  dec_tgt;
  logic [IDX_W-1:0]  dec_src;
  logic              dec_rec;
  logic [WORD_W-1:0] rnd_res;
  logic              rnd_snan;
  logic [CLS_W-1:0]  rnd_cls;
  logic              go;
  logic              snan_hit;
  logic              trap;

  fpri_decode u_dec (
    .instr    (instr),
    .op_ok    (dec_ok),
    .mode     (dec_mode),
    .tgt_idx  (dec_tgt),
    .srcr_idx (dec_src),
    .rec_bit  (dec_rec)
  );

  fpri_round u_rnd (
    .op      (src_op),
    .mode    (dec_mode),
    .res     (rnd_res),
    .is_snan (rnd_snan)
  );

  fpri_class u_cls (
    .val  (rnd_res),
    .code (rnd_cls)
  );

  assign go       = in_valid && dec_ok;
  assign snan_hit = go && rnd_snan;
  assign trap     = snan_hit && inv_enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      res_data   <= '0;
      res_we     <= 1'b0;
      res_idx    <= '0;
      src_idx    <= '0;
      unhandled  <= 1'b0;
      stat_we    <= 1'b0;
      cls_we     <= 1'b0;
      cls_code   <= '0;
      flg_fr     <= 1'b0;
      flg_fi     <= 1'b0;
      flg_vxsnan <= 1'b0;
      flg_fx     <= 1'b0;
      cond_we    <= 1'b0;
      cond_field <= '0;
    end else begin
      out_valid  <= in_valid;
      res_we     <= go && !trap;
      cls_we     <= go && !trap;
      stat_we    <= go;
      cond_we    <= go && dec_rec;
      unhandled  <= in_valid && !dec_ok;
      flg_fr     <= 1'b0;
      flg_fi     <= 1'b0;
      flg_vxsnan <= snan_hit;
      flg_fx     <= snan_hit;
      if (in_valid) begin
        res_data   <= rnd_res;
        res_idx    <= dec_tgt;
        src_idx    <= dec_src;
        cls_code   <= rnd_cls;
        cond_field <= {snan_hit, trap, snan_hit, 1'b0};
      end
    end
  end
endmodule

// File: rtl/fp_round_int_chk.sv
module fp_round_int_chk
  import fpri_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [INSTR_W-1:0]  instr,
  input logic [WORD_W-1:0]   src_op,
  input logic                inv_enable,
  input logic                out_valid,
  input logic [WORD_W-1:0]   res_data,
  input logic                res_we,
  input logic [IDX_W-1:0]    res_idx,
  input logic                unhandled,
  input logic                stat_we,
  input logic                cls_we,
  input logic                flg_vxsnan,
  input logic                cond_we
);
  logic res_is_nan;
  assign res_is_nan = (res_data[WORD_W-2 -: EXP_W] == EXP_W'(EXP_MAX)) && (res_data[FRAC_W-1:0] != '0);

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !res_we && !cls_we && !stat_we && !cond_we); // R10
  AST_UNHANDLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    out_valid && unhandled |-> !res_we && !cls_we && !stat_we && !cond_we); // R3
  AST_SNAN_TRAP: assert property (@(posedge clk) disable iff (rst)
    out_valid && flg_vxsnan && $past(inv_enable) |-> !res_we && !cls_we); // R7
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid && res_we && !res_is_nan |-> res_data[WORD_W-1] == $past(src_op[WORD_W-1])); // R6
  AST_TGT_IDX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> res_idx == $past(instr[25:21])); // R1
  AST_COND_GATE: assert property (@(posedge clk) disable iff (rst)
    out_valid && cond_we |-> $past(instr[0])); // R9
endmodule

bind fp_round_int fp_round_int_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .instr      (instr),
  .src_op     (src_op),
  .inv_enable (inv_enable),
  .out_valid  (out_valid),
  .res_data   (res_data),
  .res_we     (res_we),
  .res_idx    (res_idx),
  .unhandled  (unhandled),
  .stat_we    (stat_we),
  .cls_we     (cls_we),
  .flg_vxsnan (flg_vxsnan),
  .cond_we    (cond_we)
);

// File: tb/fp_round_int_tb_top.sv
module fp_round_int_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_op = '0;
  logic        inv_enable = 1'b0;
  logic        out_valid, res_we, unhandled, stat_we, cls_we;
  logic        flg_fr, flg_fi, flg_vxsnan, flg_fx, cond_we;
  logic [63:0] res_data;
  logic [4:0]  res_idx, src_idx, cls_code;
  logic [3:0]  cond_field;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_round_int dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src_op(src_op),
    .inv_enable(inv_enable), .out_valid(out_valid), .res_data(res_data),
    .res_we(res_we), .res_idx(res_idx), .src_idx(src_idx), .unhandled(unhandled),
    .stat_we(stat_we), .cls_we(cls_we), .cls_code(cls_code), .flg_fr(flg_fr),
    .flg_fi(flg_fi), .flg_vxsnan(flg_vxsnan), .flg_fx(flg_fx),
    .cond_we(cond_we), .cond_field(cond_field)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] x, input int xo);
    real r, t, d;
    logic [63:0] y;
    if (x[62:52] == 11'h7FF) return (x[51:0] != 0) ? (x | 64'h0008_0000_0000_0000) : x;
    if (x[62:52] >= 11'd1075) return x;
    r = $bitstoreal(x);
    t = (r >= 0.0) ? $floor(r) : $ceil(r);
    d = r - t;
    if (xo == 392) begin
      if (d >= 0.5) t = t + 1.0;
      if (d <= -0.5) t = t - 1.0;
    end else if (xo == 456) begin
      if (d > 0.0) t = t + 1.0;
    end else if (xo == 488) begin
      if (d < 0.0) t = t - 1.0;
    end
    y = $realtobits(t);
    if (t == 0.0) y = {x[63], 63'd0};
    return y;
  endfunction

  function automatic logic [4:0] cls_of(input logic [63:0] v);
    if (v[62:52] == 11'h7FF) return (v[51:0] != 0) ? 5'b10001 : (v[63] ? 5'b01001 : 5'b00101);
    if (v[62:0] == 0) return v[63] ? 5'b10010 : 5'b00010;
    return v[63] ? 5'b01000 : 5'b00100;
  endfunction

  function automatic logic [31:0] mk(input int xo, input logic [4:0] t, input logic [4:0] s, input bit rc);
    return {6'd63, t, 5'd0, s, xo[9:0], rc};
  endfunction

  task automatic issue(input logic [31:0] iw, input logic [63:0] x, input bit en);
    @(negedge clk);
    instr = iw; src_op = x; inv_enable = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // full check of one handled operation against the model
  task automatic run_op(input int xo, input logic [63:0] x, input bit en, input bit rc, input string tag);
    logic [4:0] t, s;
    logic [63:0] e;
    bit sn, trp;
    t = 5'($urandom); s = 5'($urandom);
    e = model(x, xo);
    sn = (x[62:52] == 11'h7FF) && (x[51:0] != 0) && !x[51];
    trp = sn && en;
    issue(mk(xo, t, s, rc), x, en);
    chk(out_valid && (res_we == !trp) && (trp || res_data == e), {tag, " R2 R11 result"}, res_data, e);
    chk((cls_we == !trp) && (trp || cls_code == cls_of(e)), {tag, " R8 class"}, {59'd0, cls_code}, {59'd0, cls_of(e)});
    chk(stat_we && !flg_fr && !flg_fi && flg_vxsnan == sn && flg_fx == sn && !unhandled,
        {tag, " R4 R7 flags"}, {60'd0, flg_fr, flg_fi, flg_vxsnan, flg_fx}, {62'd0, sn, sn});
    chk(cond_we == rc && (!rc || cond_field == {sn, trp, sn, 1'b0}), {tag, " R9 cond"},
        {59'd0, cond_we, cond_field}, {59'd0, rc, sn, trp, sn, 1'b0});
    chk(res_idx == t && src_idx == s, {tag, " R1 idx"}, {54'd0, res_idx, src_idx}, {54'd0, t, s});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int xos[4];
    xos[0] = 392; xos[1] = 456; xos[2] = 424; xos[3] = 488;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !res_we && !cls_we && !cond_we && !stat_we, "R10 reset state",
        {59'd0, out_valid, res_we, cls_we, cond_we, stat_we}, 64'd0);

    // directed: halves away from zero, R2
    issue(mk(392, 5'd3, 5'd4, 1'b0), 64'h4004_0000_0000_0000, 1'b0);
    chk(res_data == 64'h4008_0000_0000_0000 && res_we, "R2 nearest 2.5", res_data, 64'h4008_0000_0000_0000);
    issue(mk(392, 5'd3, 5'd4, 1'b0), 64'hC004_0000_0000_0000, 1'b0);
    chk(res_data == 64'hC008_0000_0000_0000, "R2 nearest -2.5", res_data, 64'hC008_0000_0000_0000);
    issue(mk(424, 5'd3, 5'd4, 1'b0), 64'h3FF8_0000_0000_0000, 1'b0);
    chk(res_data == 64'h3FF0_0000_0000_0000, "R11 zero 1.5", res_data, 64'h3FF0_0000_0000_0000);
    // sub-unity, R6
    issue(mk(456, 5'd1, 5'd2, 1'b0), 64'hBFD3_3333_3333_3333, 1'b0);
    chk(res_data == 64'h8000_0000_0000_0000 && cls_code == 5'b10010, "R6 up -0.3", res_data, 64'h8000_0000_0000_0000);
    issue(mk(488, 5'd1, 5'd2, 1'b0), 64'h3FE6_6666_6666_6666, 1'b0);
    chk(res_data == 64'h0, "R6 down 0.7", res_data, 64'h0);
    issue(mk(488, 5'd1, 5'd2, 1'b0), 64'hBFE6_6666_6666_6666, 1'b0);
    chk(res_data == 64'hBFF0_0000_0000_0000, "R6 down -0.7", res_data, 64'hBFF0_0000_0000_0000);
    // pass-through, R5
    issue(mk(456, 5'd1, 5'd2, 1'b0), 64'h4330_0000_0000_0001, 1'b0);
    chk(res_data == 64'h4330_0000_0000_0001, "R5 large", res_data, 64'h4330_0000_0000_0001);
    issue(mk(392, 5'd1, 5'd2, 1'b0), 64'hFFF0_0000_0000_0000, 1'b0);
    chk(res_data == 64'hFFF0_0000_0000_0000 && cls_code == 5'b01001, "R5 R8 -inf", res_data, 64'hFFF0_0000_0000_0000);
    issue(mk(424, 5'd1, 5'd2, 1'b0), 64'h7FF8_0000_0000_0001, 1'b0);
    chk(res_data == 64'h7FF8_0000_0000_0001 && !flg_vxsnan && cls_code == 5'b10001, "R5 qnan", res_data, 64'h7FF8_0000_0000_0001);
    // signaling NaN, R7
    issue(mk(424, 5'd1, 5'd2, 1'b1), 64'h7FF0_0000_0000_0001, 1'b0);
    chk(res_we && res_data == 64'h7FF8_0000_0000_0001 && flg_vxsnan && flg_fx && cond_field == 4'b1010,
        "R7 snan quieted", res_data, 64'h7FF8_0000_0000_0001);
    issue(mk(424, 5'd1, 5'd2, 1'b1), 64'h7FF0_0000_0000_0001, 1'b1);
    chk(!res_we && !cls_we && flg_vxsnan && stat_we && cond_field == 4'b1110, "R7 snan trapped",
        {59'd0, res_we, cls_we, cond_field[3:1]}, 64'd7);
    // unhandled, R3
    issue(mk(14, 5'd1, 5'd2, 1'b1), 64'h4004_0000_0000_0000, 1'b0);
    chk(unhandled && !res_we && !cls_we && !stat_we && !cond_we, "R3 bad xo",
        {59'd0, unhandled, res_we, cls_we, stat_we, cond_we}, 64'h10);
    issue({6'd31, 26'd0} | (mk(392, 5'd1, 5'd2, 1'b0) & 32'h03FF_FFFF), 64'h4004_0000_0000_0000, 1'b0);
    chk(unhandled && !res_we, "R3 bad opcode", {63'd0, unhandled}, 64'd1);
    issue(mk(392, 5'd1, 5'd2, 1'b0) | 32'h0001_0000, 64'h4004_0000_0000_0000, 1'b0);
    chk(unhandled && !res_we, "R3 reserved set", {63'd0, unhandled}, 64'd1);
    // R9 record bit gating and R10 idle
    issue(mk(456, 5'd1, 5'd2, 1'b0), 64'h3FF8_0000_0000_0000, 1'b0);
    chk(!cond_we && res_data == 64'h4000_0000_0000_0000, "R9 no record", res_data, 64'h4000_0000_0000_0000);
    @(negedge clk);
    chk(!out_valid && !res_we, "R10 idle", {62'd0, out_valid, res_we}, 64'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [63:0] x;
      int sel;
      sel = $urandom_range(0, 19);
      x = {$urandom, $urandom};
      if (sel < 14) x[62:52] = 11'(1010 + $urandom_range(0, 70));
      else if (sel == 14) x[62:52] = 11'h7FF;
      else if (sel == 15) x[62:52] = 11'd0;
      else if (sel == 16) x[51:0] = {1'b1, 51'd0} >> $urandom_range(0, 51);
      else if (sel == 17) begin x[62:52] = 11'(1023 + $urandom_range(0, 51)); x[51:0] = '1; end
      run_op(xos[$urandom_range(0, 3)], x, 1'($urandom), 1'($urandom), "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule